// File: doc/BRIEF.md
# Register Status Rename Table

This block is a small architectural register file in which every register carries a status bit. The status bit says whether the register holds a committed value or is waiting for a functional unit to produce one. Instructions are issued in program order. When an instruction issues, the table answers two source lookups. For each source it returns either a ready value or the tag of the unit that will produce the value. In the same cycle it can mark the instruction's destination register as pending on the new producer's tag.

The table also snoops a result broadcast bus that carries a tag and a value. Any pending register whose tag equals the broadcast tag takes the value and becomes ready again. A destination is claimed without waiting for earlier readers or writers of that register to finish. Write-after-write and write-after-read conflicts therefore never stall issue. Because the broadcast compares tags, a late result from an older producer cannot overwrite a newer claim.

Top module: `regstat_rename`

## Requirements
- R1: After reset every register is ready with value 0, so both source ports report ready=1, value=0, tag=0 for any index.
- R2: A source index that names a ready register, with no matching broadcast in that cycle, returns ready=1, the stored value, and tag=0.
- R3: A rename (ren_valid=1) of register ren_idx with tag ren_tag makes that register pending from the next cycle on. Reads of a pending register return ready=0, tag equal to the pending tag, and value=0.
- R4: Source reads in the cycle of a rename see the register state from before that rename.
- R5: A broadcast (bcast_valid=1) resolves every pending register whose tag equals bcast_tag. From the next cycle on, such a register is ready and holds bcast_value.
- R6: A broadcast whose tag differs from a pending register's current tag leaves that register pending with its tag unchanged. This covers an older producer finishing after the register was claimed again.
- R7: If a register is renamed in the same cycle that a broadcast matches its current tag, the rename wins and the register is pending on the new tag in the next cycle.
- R8: A source read of a pending register whose tag matches a broadcast in the same cycle returns ready=1 with bcast_value (bypass).
- R9: A register that is neither renamed nor matched by a broadcast keeps its state and value. A broadcast never changes a ready register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src0_idx | input | IDX_W | Register index for source port 0 |
| src0_ready | output | 1 | Port 0 result is a real value |
| src0_value | output | DATA_W | Port 0 value (0 when not ready) |
| src0_tag | output | TAG_W | Port 0 producer tag (0 when ready) |
| src1_idx | input | IDX_W | Register index for source port 1 |
| src1_ready | output | 1 | Port 1 result is a real value |
| src1_value | output | DATA_W | Port 1 value (0 when not ready) |
| src1_tag | output | TAG_W | Port 1 producer tag (0 when ready) |
| ren_valid | input | 1 | Claim a destination register this cycle |
| ren_idx | input | IDX_W | Destination register index |
| ren_tag | input | TAG_W | Tag of the producing unit |
| bcast_valid | input | 1 | A result is on the broadcast bus |
| bcast_tag | input | TAG_W | Tag of the unit that finished |
| bcast_value | input | DATA_W | Result value |

## Verification
The source outputs are combinational on the stored state and the broadcast inputs. The bench therefore drives every input on the falling edge and samples the source ports 1 time unit later, in the same cycle. This is where the bypass of R8 and the pre-rename view of R4 must be visible. Renames and broadcasts take effect at the next rising edge (R3, R5, R6, R7). The bench advances its own register model at that edge, and the following cycle's reads compare against it. A sweep of every register index and tag is followed by a long pseudo-random stream of renames, broadcasts and reads. Both source ports are checked every cycle.

// File: rtl/rsrt_pkg.sv
package rsrt_pkg;

    typedef enum logic [1:0] {
        SLOT_HOLD  = 2'd0,
        SLOT_CLAIM = 2'd1,
        SLOT_FILL  = 2'd2
    } slot_op_e;

    // A rename of the slot beats a result for the tag it currently holds.
    function automatic slot_op_e pick_slot_op(input logic claim,
                                              input logic pending,
                                              input logic tag_match);
        if (claim)
            return SLOT_CLAIM;
        else if (pending && tag_match)
            return SLOT_FILL;
        else
            return SLOT_HOLD;
    endfunction

endpackage

// File: rtl/rsrt_claim_dec.sv
module rsrt_claim_dec #(
    parameter int NREG  = 8,
    parameter int IDX_W = 3
) (
    input  logic             ren_valid,
    input  logic [IDX_W-1:0] ren_idx,
    output logic [NREG-1:0]  claim
);
    for (genvar g = 0; g < NREG; g++) begin : g_dec
        assign claim[g] = ren_valid && (ren_idx == IDX_W'(g));
    end
endmodule

// File: rtl/rsrt_slot.sv
module rsrt_slot
    import rsrt_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int TAG_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              claim,
    input  logic [TAG_W-1:0]  claim_tag,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_value,
    output logic              pend_o,
    output logic [TAG_W-1:0]  tag_o,
    output logic [DATA_W-1:0] val_o,
    output logic              hit_o
);
    typedef struct packed {
        logic              pend;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] val;
    } slot_t;

    slot_t    slot_d, slot_q;
    slot_op_e op;
    logic     match;

    always_comb begin
        match  = bc_valid && (bc_tag == slot_q.tag);
        op     = pick_slot_op(claim, slot_q.pend, match);
        slot_d = slot_q;
        unique case (op)
            SLOT_CLAIM: begin
                slot_d.pend = 1'b1;
                slot_d.tag  = claim_tag;
            end
            SLOT_FILL: begin
                slot_d.pend = 1'b0;
                slot_d.val  = bc_value;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            slot_q <= '0;
        else
            slot_q <= slot_d;
    end

    assign pend_o = slot_q.pend;
    assign tag_o  = slot_q.tag;
    assign val_o  = slot_q.val;
    assign hit_o  = slot_q.pend && match;
endmodule

// File: rtl/rsrt_read_port.sv
module rsrt_read_port #(
    parameter int NREG   = 8,
    parameter int IDX_W  = 3,
    parameter int DATA_W = 16,
    parameter int TAG_W  = 3
) (
    input  logic [IDX_W-1:0]             idx,
    input  logic [NREG-1:0]              pend,
    input  logic [NREG-1:0][TAG_W-1:0]   tags,
    input  logic [NREG-1:0][DATA_W-1:0]  vals,
    input  logic [NREG-1:0]              hits,
    input  logic [DATA_W-1:0]            bc_value,
    output logic                         ready,
    output logic [DATA_W-1:0]            value,
    output logic [TAG_W-1:0]             tag
);
    always_comb begin
        ready = 1'b1;
        value = vals[idx];
        tag   = '0;
        if (hits[idx]) begin
            value = bc_value;
        end else if (pend[idx]) begin
            ready = 1'b0;
            value = '0;
            tag   = tags[idx];
        end
    end
endmodule

// File: rtl/regstat_rename.sv
module regstat_rename #(
    parameter int NREG   = 8,
    parameter int DATA_W = 16,
    parameter int TAG_W  = 3,
    localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  src0_idx,
    output logic              src0_ready,
    output logic [DATA_W-1:0] src0_value,
    output logic [TAG_W-1:0]  src0_tag,
    input  logic [IDX_W-1:0]  src1_idx,
    output logic              src1_ready,
    output logic [DATA_W-1:0] src1_value,
    output logic [TAG_W-1:0]  src1_tag,
    input  logic              ren_valid,
    input  logic [IDX_W-1:0]  ren_idx,
    input  logic [TAG_W-1:0]  ren_tag,
    input  logic              bcast_valid,
    input  logic [TAG_W-1:0]  bcast_tag,
    input  logic [DATA_W-1:0] bcast_value
);
    localparam int NPORT = 2;

    logic [NREG-1:0]             claim;
    logic [NREG-1:0]             ent_pend;
    logic [NREG-1:0][TAG_W-1:0]  ent_tag;
    logic [NREG-1:0][DATA_W-1:0] ent_val;
    logic [NREG-1:0]             ent_hit;

    logic [NPORT-1:0][IDX_W-1:0]  rd_idx;
    logic [NPORT-1:0]             rd_ready;
    logic [NPORT-1:0][DATA_W-1:0] rd_value;
    logic [NPORT-1:0][TAG_W-1:0]  rd_tag;

    rsrt_claim_dec #(.NREG(NREG), .IDX_W(IDX_W)) u_dec (
        .ren_valid (ren_valid),
        .ren_idx   (ren_idx),
        .claim     (claim)
    );

    for (genvar g = 0; g < NREG; g++) begin : g_slot
        rsrt_slot #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .claim     (claim[g]),
            .claim_tag (ren_tag),
            .bc_valid  (bcast_valid),
            .bc_tag    (bcast_tag),
            .bc_value  (bcast_value),
            .pend_o    (ent_pend[g]),
            .tag_o     (ent_tag[g]),
            .val_o     (ent_val[g]),
            .hit_o     (ent_hit[g])
        );
    end

    assign rd_idx[0] = src0_idx;
    assign rd_idx[1] = src1_idx;

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        rsrt_read_port #(
            .NREG(NREG), .IDX_W(IDX_W), .DATA_W(DATA_W), .TAG_W(TAG_W)
        ) u_rd (
            .idx      (rd_idx[p]),
            .pend     (ent_pend),
            .tags     (ent_tag),
            .vals     (ent_val),
            .hits     (ent_hit),
            .bc_value (bcast_value),
            .ready    (rd_ready[p]),
            .value    (rd_value[p]),
            .tag      (rd_tag[p])
        );
    end

    assign src0_ready = rd_ready[0];
    assign src0_value = rd_value[0];
    assign src0_tag   = rd_tag[0];
    assign src1_ready = rd_ready[1];
    assign src1_value = rd_value[1];
    assign src1_tag   = rd_tag[1];
endmodule

// File: rtl/regstat_rename_chk.sv
module regstat_rename_chk #(
    parameter int NREG   = 8,
    parameter int DATA_W = 16,
    parameter int TAG_W  = 3,
    parameter int IDX_W  = 3
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [IDX_W-1:0]            src0_idx,
    input logic                        src0_ready,
    input logic [DATA_W-1:0]           src0_value,
    input logic                        ren_valid,
    input logic [IDX_W-1:0]            ren_idx,
    input logic [TAG_W-1:0]            ren_tag,
    input logic                        bcast_valid,
    input logic [TAG_W-1:0]            bcast_tag,
    input logic [DATA_W-1:0]           bcast_value,
    input logic [NREG-1:0]             ent_pend,
    input logic [NREG-1:0][TAG_W-1:0]  ent_tag,
    input logic [NREG-1:0][DATA_W-1:0] ent_val
);
    // R3 and R7: a claimed register is pending on the new tag next cycle.
    assert_claim_sets_tag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ren_valid |=> ent_pend[$past(ren_idx)] && ent_tag[$past(ren_idx)] == $past(ren_tag));

    // R8: a same-cycle match is bypassed to the source port.
    assert_bypass_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ent_pend[src0_idx] && bcast_valid && bcast_tag == ent_tag[src0_idx])
        |-> (src0_ready && src0_value == bcast_value));

    for (genvar g = 0; g < NREG; g++) begin : g_chk
        // R5: a matching result resolves the register.
        assert_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (ent_pend[g] && bcast_valid && bcast_tag == ent_tag[g]
             && !(ren_valid && ren_idx == IDX_W'(g)))
            |=> (!ent_pend[g] && ent_val[g] == $past(bcast_value)));

        // R6: a result for another tag leaves a pending register alone.
        assert_stale_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (ent_pend[g] && !(bcast_valid && bcast_tag == ent_tag[g])
             && !(ren_valid && ren_idx == IDX_W'(g)))
            |=> (ent_pend[g] && $stable(ent_tag[g])));

        // R9: a ready register without a claim keeps its value.
        assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (!ent_pend[g] && !(ren_valid && ren_idx == IDX_W'(g)))
            |=> (!ent_pend[g] && $stable(ent_val[g])));
    end
endmodule

bind regstat_rename regstat_rename_chk #(
    .NREG(NREG), .DATA_W(DATA_W), .TAG_W(TAG_W), .IDX_W(IDX_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .src0_idx    (src0_idx),
    .src0_ready  (src0_ready),
    .src0_value  (src0_value),
    .ren_valid   (ren_valid),
    .ren_idx     (ren_idx),
    .ren_tag     (ren_tag),
    .bcast_valid (bcast_valid),
    .bcast_tag   (bcast_tag),
    .bcast_value (bcast_value),
    .ent_pend    (ent_pend),
    .ent_tag     (ent_tag),
    .ent_val     (ent_val)
);

// File: tb/regstat_rename_tb.sv
module regstat_rename_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NREG   = 8;
    localparam int DATA_W = 16;
    localparam int TAG_W  = 3;
    localparam int IDX_W  = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [IDX_W-1:0]  src0_idx = '0, src1_idx = '0;
    logic              src0_ready, src1_ready;
    logic [DATA_W-1:0] src0_value, src1_value;
    logic [TAG_W-1:0]  src0_tag, src1_tag;
    logic              ren_valid = 1'b0;
    logic [IDX_W-1:0]  ren_idx = '0;
    logic [TAG_W-1:0]  ren_tag = '0;
    logic              bcast_valid = 1'b0;
    logic [TAG_W-1:0]  bcast_tag = '0;
    logic [DATA_W-1:0] bcast_value = '0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic              m_pend [NREG];
    logic [TAG_W-1:0]  m_tag  [NREG];
    logic [DATA_W-1:0] m_val  [NREG];
    logic [31:0]       lfsr = 32'h1ACE_B00C;

    always #(CLK_PERIOD/2) clk = ~clk;

    regstat_rename #(.NREG(NREG), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .src0_idx(src0_idx), .src0_ready(src0_ready), .src0_value(src0_value), .src0_tag(src0_tag),
        .src1_idx(src1_idx), .src1_ready(src1_ready), .src1_value(src1_value), .src1_tag(src1_tag),
        .ren_valid(ren_valid), .ren_idx(ren_idx), .ren_tag(ren_tag),
        .bcast_valid(bcast_valid), .bcast_tag(bcast_tag), .bcast_value(bcast_value)
    );

    task automatic check_port(input string req, input int port, input logic [IDX_W-1:0] idx,
                              input logic rdy, input logic [DATA_W-1:0] val,
                              input logic [TAG_W-1:0] tg);
        logic              e_rdy;
        logic [DATA_W-1:0] e_val;
        logic [TAG_W-1:0]  e_tag;
        if (m_pend[idx] && bcast_valid && bcast_tag == m_tag[idx]) begin
            e_rdy = 1'b1; e_val = bcast_value; e_tag = '0;
        end else if (m_pend[idx]) begin
            e_rdy = 1'b0; e_val = '0; e_tag = m_tag[idx];
        end else begin
            e_rdy = 1'b1; e_val = m_val[idx]; e_tag = '0;
        end
        checks++;
        if ({rdy, val, tg} !== {e_rdy, e_val, e_tag}) begin
            fails++;
            $display("FAIL %s port%0d reg%0d: got rdy=%0b val=%0h tag=%0d, expected rdy=%0b val=%0h tag=%0d",
                     req, port, idx, rdy, val, tg, e_rdy, e_val, e_tag);
        end
    endtask

    function automatic string auto_req(input logic [IDX_W-1:0] idx);
        if (m_pend[idx] && bcast_valid && bcast_tag == m_tag[idx]) return "R8";
        if (m_pend[idx]) return "R3";
        return "R9";
    endfunction

    // One cycle: drive on the falling edge, sample 1 unit later, model steps at the rising edge.
    task automatic step(input logic rv, input logic [IDX_W-1:0] ri, input logic [TAG_W-1:0] rt,
                        input logic bv, input logic [TAG_W-1:0] bt, input logic [DATA_W-1:0] bval,
                        input logic [IDX_W-1:0] s0, input logic [IDX_W-1:0] s1, input string req);
        @(negedge clk);
        ren_valid = rv; ren_idx = ri; ren_tag = rt;
        bcast_valid = bv; bcast_tag = bt; bcast_value = bval;
        src0_idx = s0; src1_idx = s1;
        #1;
        check_port((req == "") ? auto_req(s0) : req, 0, s0, src0_ready, src0_value, src0_tag);
        check_port((req == "") ? auto_req(s1) : req, 1, s1, src1_ready, src1_value, src1_tag);
        @(posedge clk);
        for (int i = 0; i < NREG; i++) begin
            if (rv && ri == IDX_W'(i)) begin
                m_pend[i] = 1'b1; m_tag[i] = rt;
            end else if (m_pend[i] && bv && bt == m_tag[i]) begin
                m_pend[i] = 1'b0; m_val[i] = bval;
            end
        end
    endtask

    task automatic idle_read(input logic [IDX_W-1:0] s0, input logic [IDX_W-1:0] s1, input string req);
        step(1'b0, '0, '0, 1'b0, '0, '0, s0, s1, req);
    endtask

    initial begin
        for (int i = 0; i < NREG; i++) begin
            m_pend[i] = 1'b0; m_tag[i] = '0; m_val[i] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state on every register, both ports
        for (int i = 0; i < NREG; i++)
            idle_read(IDX_W'(i), IDX_W'(NREG - 1 - i), "R1");

        // R4: rename each register while reading it; the read sees the old state
        for (int i = 0; i < NREG; i++)
            step(1'b1, IDX_W'(i), TAG_W'(i), 1'b0, '0, '0, IDX_W'(i), IDX_W'(i), "R4");
        // R3: all registers now pending on their own tag
        for (int i = 0; i < NREG; i++)
            idle_read(IDX_W'(i), IDX_W'((i + 3) % NREG), "R3");

        // R8: broadcast each tag while reading its register; R5 next cycle
        for (int i = 0; i < NREG; i++) begin
            step(1'b0, '0, '0, 1'b1, TAG_W'(i), DATA_W'(16'h1000 + i * 16'h0111),
                 IDX_W'(i), IDX_W'(i), "R8");
            idle_read(IDX_W'(i), IDX_W'(i), "R5");
        end
        // R2: ready registers return stored values
        for (int i = 0; i < NREG; i++)
            idle_read(IDX_W'(i), IDX_W'((i + 1) % NREG), "R2");

        // R6: older producer finishes after the register was claimed again
        step(1'b1, 3'd2, 3'd5, 1'b0, '0, '0, 3'd0, 3'd1, "");
        step(1'b1, 3'd2, 3'd6, 1'b0, '0, '0, 3'd0, 3'd1, "");
        step(1'b0, '0, '0, 1'b1, 3'd5, 16'hDEAD, 3'd0, 3'd1, "R6");
        idle_read(3'd2, 3'd2, "R6");
        step(1'b0, '0, '0, 1'b1, 3'd6, 16'hBEEF, 3'd2, 3'd2, "R8");
        idle_read(3'd2, 3'd2, "R5");

        // R7: rename and matching broadcast on the same register in one cycle
        step(1'b1, 3'd3, 3'd1, 1'b0, '0, '0, 3'd0, 3'd0, "");
        step(1'b1, 3'd3, 3'd2, 1'b1, 3'd1, 16'h5A5A, 3'd3, 3'd3, "R8");
        idle_read(3'd3, 3'd3, "R7");
        step(1'b0, '0, '0, 1'b1, 3'd2, 16'hA5A5, 3'd3, 3'd3, "R8");
        idle_read(3'd3, 3'd3, "R5");

        // R9: a broadcast with an unused tag leaves every ready register unchanged
        step(1'b0, '0, '0, 1'b1, 3'd7, 16'hFFFF, 3'd0, 3'd1, "R9");
        for (int i = 0; i < NREG; i++)
            idle_read(IDX_W'(i), IDX_W'(i), "R9");

        // Pseudo-random stream over all registers, tags and both ports
        for (int n = 0; n < 4000; n++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            step(lfsr[0], lfsr[3:1], lfsr[6:4], lfsr[7] | lfsr[8], lfsr[11:9],
                 lfsr[27:12], lfsr[30:28], lfsr[14:12], "");
        end

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog: got timeout, expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule